// File: doc/BRIEF.md
# Register-Configured IO Pad Function Router

This block sits between a fixed row of IO pads and the peripheral functions that share them, GPIO among them. Every pad owns one select register. The value in that register chooses which of the pad's functions drives the pad's output value and output-enable. The same value also chooses which function's input receives the value read from the pad. One select value therefore steers both data directions and the direction control together.

Software programs the selects through a plain register port. The write side reports at once whether the address hits a pad. The read side returns an error flag together with the zero-extended select value.

Each function slot is numbered `pad * NUM_FUNCS + func`. Its kind is fixed by a 2-bit parameter field. A function is input-only, output-only or bidirectional, and a bidirectional function brings its own enable. Any pad output or enable that the selected function does not drive is held at zero. A function input that no pad currently selects also reads zero.

Top module: `pad_route_mux`

## Requirements
- R1: After reset every select register reads 0, so every pad routes to its function 0.
- R2: A write to a valid index stores the low SEL_W bits of the write data, where SEL_W = clog2(NUM_FUNCS) and is at least 1. The new value is visible from the next clock edge. A read returns it zero-extended to DATA_W bits.
- R3: The register index is taken from address bits [IDX_HI:IDX_LO], and index value p selects pad p. All other address bits are ignored.
- R4: `wr_ok_o` is 1 exactly when the write index is below NUM_PADS. A write with an unmatched index changes no select register.
- R5: A read with an unmatched index raises `rd_err_o` and returns zero data. A matched read has `rd_err_o` = 0.
- R6: The slot kind field FN_KINDS[2*slot+1:2*slot] encodes 00 input-only, 01 output-only and 10 bidirectional. When a bidirectional function is selected, the pad output follows its out signal, the pad enable follows its enable signal, and its input follows the pad.
- R7: When an output-only function is selected, the pad output follows its out signal and the pad enable is 1. Its input reads 0.
- R8: When an input-only function is selected, the pad output and enable are 0, and its input follows the pad.
- R9: A select value of NUM_FUNCS or more drives pad output 0 and enable 0. No function input of that pad follows the pad.
- R10: Every function input whose function is not selected reads 0. The out and enable signals of unselected functions have no effect on the pads.
- R11: With default parameters, function 0 of each pad is bidirectional, function 1 is output-only and function 2 is input-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write strobe for the select registers |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data, truncated to SEL_W |
| wr_ok_o | output | 1 | Write address hits a pad |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Addressed select value, zero-extended |
| rd_err_o | output | 1 | Read address hits no pad |
| pad_in_i | input | NUM_PADS | Value read from each pad |
| pad_out_o | output | NUM_PADS | Value driven to each pad |
| pad_oe_o | output | NUM_PADS | Output-enable for each pad |
| fn_out_i | input | NUM_PADS*NUM_FUNCS | Out signal of each function slot |
| fn_oe_i | input | NUM_PADS*NUM_FUNCS | Enable of each bidirectional slot |
| fn_in_o | output | NUM_PADS*NUM_FUNCS | Input delivered to each function slot |

## Verification
Directed writes place each pad in turn on a bidirectional, an output-only, an input-only and an out-of-range select. Comparing pad output, enable and every function input then tells the three kinds apart from each other and from the zero fill. Addresses with the high bits set, or with an index past the last pad, separate the index slice from the rest of the address and show that misses leave the registers untouched. Random phases with toggling out, enable and pad-in vectors on unselected slots show that those slots cannot leak onto a pad. Random write data with high bits set exercises truncation.

// File: rtl/pmux_pkg.sv
package pmux_pkg;
  typedef enum logic [1:0] {
    FK_IN    = 2'b00,
    FK_OUT   = 2'b01,
    FK_BIDIR = 2'b10,
    FK_NONE  = 2'b11
  } fn_kind_e;

  function automatic int unsigned sel_width(input int unsigned nfuncs);
    return (nfuncs > 1) ? $clog2(nfuncs) : 1;
  endfunction
endpackage

// File: rtl/pmux_rst_sync.sv
module pmux_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/pmux_sel_bank.sv
module pmux_sel_bank #(
  parameter int unsigned NUM_PADS = 4,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_HI   = 4,
  parameter int unsigned IDX_LO   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic                           wr_ok_o,
  input  logic [ADDR_W-1:0]              rd_addr_i,
  output logic [DATA_W-1:0]              rd_data_o,
  output logic                           rd_err_o,
  output logic [NUM_PADS-1:0][SEL_W-1:0] sel_o
);
  localparam int unsigned IDX_W = IDX_HI - IDX_LO + 1;

  logic [IDX_W-1:0]              widx, ridx;
  logic [NUM_PADS-1:0][SEL_W-1:0] sel_q, sel_d;
  logic [NUM_PADS-1:0]           reg_en;
  logic                          wr_hit, rd_hit;

  assign widx   = wr_addr_i[IDX_HI:IDX_LO];
  assign ridx   = rd_addr_i[IDX_HI:IDX_LO];
  assign wr_hit = int'(widx) < int'(NUM_PADS);
  assign rd_hit = int'(ridx) < int'(NUM_PADS);

  // next state: per-register clock enables from the decoded index
  always_comb begin
    sel_d = sel_q;
    for (int p = 0; p < int'(NUM_PADS); p++) begin
      reg_en[p] = wr_en_i && (int'(widx) == p);
      if (reg_en[p]) sel_d[p] = wr_data_i[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (|reg_en) sel_q <= sel_d;
  end

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < int'(NUM_PADS); p++)
      if (int'(ridx) == p) rd_data_o = DATA_W'(sel_q[p]);
  end

  assign rd_err_o = !rd_hit;
  assign wr_ok_o  = wr_hit;
  assign sel_o    = sel_q;

  // R4
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_ok_o) |=> $stable(sel_q));

  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_o |-> (rd_data_o == '0));

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_store
    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && int'(widx) == p) |=> (sel_q[p] == $past(wr_data_i[SEL_W-1:0])));
  end
endmodule

// File: rtl/pmux_pad_route.sv
module pmux_pad_route
  import pmux_pkg::*;
#(
  parameter int unsigned             NUM_FUNCS = 3,
  parameter int unsigned             SEL_W     = 2,
  parameter logic [2*NUM_FUNCS-1:0]  KINDS     = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 pad_in_i,
  input  logic [NUM_FUNCS-1:0] fn_out_i,
  input  logic [NUM_FUNCS-1:0] fn_oe_i,
  output logic                 pad_out_o,
  output logic                 pad_oe_o,
  output logic [NUM_FUNCS-1:0] fn_in_o
);
  logic [NUM_FUNCS-1:0] hit;
  logic [NUM_FUNCS-1:0] drv_out, drv_oe;

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
    localparam fn_kind_e KIND = fn_kind_e'(KINDS[2*f +: 2]);
    assign hit[f] = (int'(sel_i) == f);
    if (KIND == FK_BIDIR) begin : g_bidir
      assign drv_out[f] = hit[f] & fn_out_i[f];
      assign drv_oe[f]  = hit[f] & fn_oe_i[f];
      assign fn_in_o[f] = hit[f] & pad_in_i;
    end else if (KIND == FK_OUT) begin : g_out
      assign drv_out[f] = hit[f] & fn_out_i[f];
      assign drv_oe[f]  = hit[f];
      assign fn_in_o[f] = 1'b0;
    end else if (KIND == FK_IN) begin : g_in
      assign drv_out[f] = 1'b0;
      assign drv_oe[f]  = 1'b0;
      assign fn_in_o[f] = hit[f] & pad_in_i;
    end else begin : g_none
      assign drv_out[f] = 1'b0;
      assign drv_oe[f]  = 1'b0;
      assign fn_in_o[f] = 1'b0;
    end
  end

  // at most one hit bit is set, so OR-reduction acts as the mux
  assign pad_out_o = |drv_out;
  assign pad_oe_o  = |drv_oe;

  // R9
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_i) >= int'(NUM_FUNCS)) |-> (!pad_out_o && !pad_oe_o && fn_in_o == '0));

  // R10
  single_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fn_in_o));
endmodule

// File: rtl/pad_route_mux.sv
module pad_route_mux
  import pmux_pkg::*;
#(
  parameter int unsigned NUM_PADS  = 4,
  parameter int unsigned NUM_FUNCS = 3,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_HI    = 4,
  parameter int unsigned IDX_LO    = 2,
  parameter logic [2*NUM_PADS*NUM_FUNCS-1:0] FN_KINDS = 24'h186186
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic                          wr_ok_o,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic                          rd_err_o,
  input  logic [NUM_PADS-1:0]           pad_in_i,
  output logic [NUM_PADS-1:0]           pad_out_o,
  output logic [NUM_PADS-1:0]           pad_oe_o,
  input  logic [NUM_PADS*NUM_FUNCS-1:0] fn_out_i,
  input  logic [NUM_PADS*NUM_FUNCS-1:0] fn_oe_i,
  output logic [NUM_PADS*NUM_FUNCS-1:0] fn_in_o
);
  localparam int unsigned SEL_W = sel_width(NUM_FUNCS);

  logic                           rst_n;
  logic [NUM_PADS-1:0][SEL_W-1:0] sel;

  pmux_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  pmux_sel_bank #(
    .NUM_PADS (NUM_PADS),
    .SEL_W    (SEL_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IDX_HI   (IDX_HI),
    .IDX_LO   (IDX_LO)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wr_ok_o   (wr_ok_o),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .rd_err_o  (rd_err_o),
    .sel_o     (sel)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    pmux_pad_route #(
      .NUM_FUNCS (NUM_FUNCS),
      .SEL_W     (SEL_W),
      .KINDS     (FN_KINDS[2*NUM_FUNCS*p +: 2*NUM_FUNCS])
    ) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (sel[p]),
      .pad_in_i  (pad_in_i[p]),
      .fn_out_i  (fn_out_i[NUM_FUNCS*p +: NUM_FUNCS]),
      .fn_oe_i   (fn_oe_i[NUM_FUNCS*p +: NUM_FUNCS]),
      .pad_out_o (pad_out_o[p]),
      .pad_oe_o  (pad_oe_o[p]),
      .fn_in_o   (fn_in_o[NUM_FUNCS*p +: NUM_FUNCS])
    );
  end
endmodule

// File: tb/sim_pad_route_mux.sv
`timescale 1ns/1ps
module sim_pad_route_mux;
  localparam int NP = 4;
  localparam int NF = 3;
  localparam int SW = 2;
  localparam int NS = NP * NF;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [7:0]    wr_addr_i = '0;
  logic [31:0]   wr_data_i = '0;
  logic          wr_ok_o;
  logic [7:0]    rd_addr_i = '0;
  logic [31:0]   rd_data_o;
  logic          rd_err_o;
  logic [NP-1:0] pad_in_i = '0;
  logic [NP-1:0] pad_out_o, pad_oe_o;
  logic [NS-1:0] fn_out_i = '0, fn_oe_i = '0, fn_in_o;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [SW-1:0] m_sel [NP];
  logic [NP-1:0] e_out, e_oe;
  logic [NS-1:0] e_in;

  always #2 clk = ~clk;

  pad_route_mux u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R11 default kinds: func 0 bidir, func 1 output-only, func 2 input-only
  task automatic model_route();
    e_out = '0; e_oe = '0; e_in = '0;
    for (int p = 0; p < NP; p++) begin
      case (m_sel[p])
        2'd0: begin e_out[p] = fn_out_i[p*NF];   e_oe[p] = fn_oe_i[p*NF]; e_in[p*NF] = pad_in_i[p]; end // R6
        2'd1: begin e_out[p] = fn_out_i[p*NF+1]; e_oe[p] = 1'b1; end                              // R7
        2'd2: e_in[p*NF+2] = pad_in_i[p];                                                        // R8
        default: ;                                                                               // R9
      endcase
    end
  endtask

  // sample mid-cycle: compare combinational outputs against the model
  task automatic check_all(input string why);
    int ri;
    bit hit;
    model_route();
    chk(pad_out_o == e_out, {"R6 R7 R8 R9 R10 pad_out ", why}, 64'(pad_out_o), 64'(e_out));
    chk(pad_oe_o == e_oe,   {"R6 R7 R8 R9 R10 pad_oe ", why},  64'(pad_oe_o), 64'(e_oe));
    chk(fn_in_o == e_in,    {"R6 R7 R8 R9 R10 fn_in ", why},   64'(fn_in_o), 64'(e_in));
    ri = int'(rd_addr_i[4:2]);
    hit = ri < NP;
    chk(rd_err_o == !hit, {"R5 rd_err ", why}, 64'(rd_err_o), 64'(!hit));
    chk(rd_data_o == (hit ? 32'(m_sel[ri]) : 32'd0), {"R2 R3 R5 rd_data ", why},
        64'(rd_data_o), hit ? 64'(m_sel[ri]) : 64'd0);
    chk(wr_ok_o == (int'(wr_addr_i[4:2]) < NP), {"R4 wr_ok ", why},
        64'(wr_ok_o), 64'(int'(wr_addr_i[4:2]) < NP));
  endtask

  // one cycle: drive at negedge, check, then commit at posedge
  task automatic step(input bit we, input logic [7:0] wa, input logic [31:0] wd,
                      input logic [7:0] ra, input string why);
    @(negedge clk);
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd; rd_addr_i = ra;
    #0.5;
    check_all(why);
    @(posedge clk);
    if (we && int'(wa[4:2]) < NP) m_sel[int'(wa[4:2])] = wd[SW-1:0];
  endtask

  task automatic read_all(input string why);
    for (int p = 0; p < NP; p++) step(1'b0, 8'h00, 32'h0, 8'(p << 2), why);
  endtask

  initial begin
    void'($urandom(32'd20241));
    for (int p = 0; p < NP; p++) m_sel[p] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    pad_in_i = 4'b1010; fn_out_i = 12'hFFF; fn_oe_i = 12'h555;
    read_all("R1 reset");
    // R2 truncation and R8 input-only on pad 2
    step(1'b1, 8'h08, 32'hFFFF_FFFE, 8'h08, "R2 write pad2");
    step(1'b0, 8'h00, 32'h0, 8'h08, "R2 R8 readback pad2");
    // R3 high and low address bits ignored
    step(1'b1, 8'hE7, 32'h0000_0001, 8'hE4, "R3 write pad1 high bits");
    step(1'b0, 8'h00, 32'h0, 8'h07, "R3 R7 readback pad1");
    // R4 and R5 unmatched index 5
    step(1'b1, 8'h14, 32'h3, 8'h14, "R4 R5 miss write");
    read_all("R4 registers unchanged");
    step(1'b0, 8'h00, 32'h0, 8'h1C, "R5 miss read index 7");
    // R9 out-of-range select on pad 3
    step(1'b1, 8'h0C, 32'h3, 8'h0C, "R9 write pad3 out of range");
    pad_in_i = 4'hF; fn_out_i = 12'hFFF; fn_oe_i = 12'hFFF;
    step(1'b0, 8'h00, 32'h0, 8'h0C, "R9 pad3 all ones in");
    // R10 unselected slots toggle without effect
    fn_out_i = 12'h000; fn_oe_i = 12'h000; pad_in_i = 4'h0;
    step(1'b0, 8'h00, 32'h0, 8'h00, "R10 all zero");
    // R6 bidir enable follows function
    step(1'b1, 8'h00, 32'h4, 8'h00, "R6 pad0 bidir");
    fn_out_i = 12'h001; fn_oe_i = 12'h001; pad_in_i = 4'h1;
    step(1'b0, 8'h00, 32'h0, 8'h00, "R6 pad0 driven");
    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [7:0] wa, ra;
      wa = 8'($urandom); ra = 8'($urandom);
      pad_in_i = 4'($urandom); fn_out_i = 12'($urandom); fn_oe_i = 12'($urandom);
      step(1'($urandom), wa, $urandom, ra, "random");
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule